// File: doc/BRIEF.md
# Calibrated Thermal Code Converter with Bank and Frame Maximum

This block turns 12-bit raw thermal sensor codes into signed temperatures in millidegrees Celsius, using calibration constants decoded from a three-word fuse image. A constant gain factor is derived from two of the calibration fields by a multi-cycle divider. Each converted value is then formed in a single cycle from that gain, a per-sensor offset and a reference temperature. Readings far too hot to be real are forced to zero. The block keeps the hottest value of each sensor bank and the hottest value across all banks.

Readings arrive as beats on a valid/ready stream. Each beat carries a sensor index, a bank index, a raw code and two end markers. A beat with the bank marker closes the bank that is open. A beat with the frame marker closes that bank and also ends the frame. When a frame ends, the block registers every bank's maximum and the overall maximum and raises a one-cycle strobe. These outputs then stay unchanged until the next frame ends. Pulsing the fuse-load input latches new calibration and recomputes the gain. While the gain is being computed the block reports busy and takes no beats.

The control FSM has three states. CTL_START issues the divider start. CTL_DIVIDE waits for the divider to finish. CTL_READY accepts beats. The transitions are: CTL_START to CTL_DIVIDE always; CTL_DIVIDE to CTL_READY when the divider reports done; and from any state to CTL_START on a fuse load or on leaving reset. The divider FSM has three states. DV_IDLE goes to DV_FIRST on start. DV_FIRST goes to DV_SECOND after its last step. DV_SECOND goes to DV_IDLE after its last step. A start in any state goes to DV_FIRST.

Top module: `thermconv_top`

## Requirements
- R1: Only bits 11:0 of in_raw take part in the conversion; bits 15:12 have no effect on any output.
- R2: gain = floor(floor(1627604160 / (165 + slope)) / (10000 + adc_ge)). It is recomputed after reset and after every fuse_load pulse. From the cycle after the pulse until the result is ready, busy is 1 and in_ready is 0, and this lasts under 100 cycles.
- R3: A beat converts to degc × 500 − ((gain × (raw − vts[sensor] − 3350)) >>> 3), computed in signed 32-bit arithmetic. The sensor index must be 0 to 4, and each index selects its own vts.
- R4: A converted value greater than 200000 is replaced by 0 before any maximum is taken.
- R5: A bank's value is the maximum of the beats from the previous close through the closing beat. A beat closes a bank when it has in_last_bank or in_last_frame set. The value is filed under the closing beat's bank index. If the same bank index is closed twice in one frame, the larger result is kept.
- R6: global_max is the maximum of all bank values in the frame. A bank that was not closed in the frame reports 0x80000000 (the most negative value). bank_max holds bank i in bits 32i+31:32i.
- R7: out_valid is high for exactly one cycle. That cycle follows the clock edge that accepted an in_last_frame beat. bank_max and global_max change only at that point and hold otherwise, even while a later frame is partly received.
- R8: After reset, out_valid is 0, global_max and every bank_max slice are 0x80000000, busy is 1, and the default calibration is in use.
- R9: If bit 0 of word 0 is set, fuse_load decodes the fields below. degc comes from word 0 bits 6:1. The slope magnitude comes from word 0 bits 31:26. adc_ge comes from word 1 bits 31:22. vts[0] comes from word 0 bits 25:17 and vts[1] from word 0 bits 16:8. vts[2] comes from word 1 bits 8:0. vts[3] comes from word 2 bits 31:23 and vts[4] from word 2 bits 22:14.
- R10: The slope is the negated magnitude only when word 0 bit 7 and word 1 bit 9 are both 1; otherwise it is the magnitude itself.
- R11: If bit 0 of word 0 is clear, fuse_load loads the default calibration and ignores every other field. The defaults are adc_ge 512, every vts 260, degc 40 and slope 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fuse_load | input | 1 | Pulse that latches the fuse words and restarts the gain computation |
| fuse_w0 | input | 32 | Fuse word 0 |
| fuse_w1 | input | 32 | Fuse word 1 |
| fuse_w2 | input | 32 | Fuse word 2 |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| in_sensor | input | 3 | Sensor index, 0 to 4 |
| in_bank | input | 2 | Bank index of the beat |
| in_raw | input | 16 | Raw code; only the low 12 bits are used |
| in_last_bank | input | 1 | Beat closes the open bank |
| in_last_frame | input | 1 | Beat closes the open bank and ends the frame |
| busy | output | 1 | Gain computation in progress |
| out_valid | output | 1 | One-cycle strobe when new results are registered |
| bank_max | output | 128 | Per-bank maxima, 32 signed bits per bank |
| global_max | output | 32 | Maximum over all banks, signed |

## Verification
A wrong gain, a wrong vts selection or a bad fuse field shows up in the first single-beat frame converted afterwards. The error appears at bank_max and global_max on the cycle after that beat is accepted. Sweeping the raw code across its range for every sensor and several calibrations exposes any slice or sign error. A corrupted running maximum or bank staging register appears as a wrong bank slice or a wrong overall maximum at the very next frame end. A control state that fails to leave busy appears as a stalled in_ready within the bound given in R2.

// File: rtl/thermconv_pkg.sv
package thermconv_pkg;

    localparam int TEMP_W      = 32;
    localparam int CODE_BITS   = 12;
    localparam int NUM_VTS     = 5;
    localparam int VTS_W       = 9;
    localparam int GE_W        = 10;
    localparam int DEGC_W      = 6;
    localparam int SLOPE_W     = 7;

    localparam logic signed [TEMP_W-1:0] TEMP_FLOOR  = 32'sh8000_0000;
    localparam logic        [TEMP_W-1:0] GAIN_NUMER  = 32'd1627604160;
    localparam logic signed [TEMP_W-1:0] SPIKE_LIMIT = 32'sd200000;
    localparam logic signed [TEMP_W-1:0] CODE_BIAS   = 32'sd3350;
    localparam int SLOPE_BASE = 165;
    localparam int GE_BASE    = 10000;

    typedef struct packed {
        logic        [GE_W-1:0]               adc_ge;
        logic        [DEGC_W-1:0]             degc;
        logic signed [SLOPE_W-1:0]            slope;
        logic        [NUM_VTS-1:0][VTS_W-1:0] vts;
    } calib_t;

    typedef enum logic [1:0] {CTL_START, CTL_DIVIDE, CTL_READY} ctl_state_t;
    typedef enum logic [1:0] {DV_IDLE, DV_FIRST, DV_SECOND}     div_state_t;

    function automatic calib_t calib_default();
        calib_t c;
        c.adc_ge = 10'd512;
        c.degc   = 6'd40;
        c.slope  = '0;
        for (int i = 0; i < NUM_VTS; i++) c.vts[i] = 9'd260;
        return c;
    endfunction

endpackage

// File: rtl/thermconv_fuse_decode.sv
module thermconv_fuse_decode
    import thermconv_pkg::*;
(
    input  logic [31:0] w0,
    input  logic [31:0] w1,
    input  logic [31:0] w2,
    output calib_t      cal
);
    logic signed [SLOPE_W-1:0] mag;

    assign mag = $signed({1'b0, w0[31:26]});

    always_comb begin
        cal = calib_default();
        if (w0[0]) begin
            cal.adc_ge = w1[31:22];
            cal.degc   = w0[6:1];
            cal.vts[0] = w0[25:17];
            cal.vts[1] = w0[16:8];
            cal.vts[2] = w1[8:0];
            cal.vts[3] = w2[31:23];
            cal.vts[4] = w2[22:14];
            cal.slope  = (w0[7] && w1[9]) ? -mag : mag;
        end
    end
endmodule

// File: rtl/thermconv_gain_div.sv
module thermconv_gain_div
    import thermconv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] numer,
    input  logic [W-1:0] div_a,
    input  logic [W-1:0] div_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

    div_state_t       state_q, state_d;
    logic [W-1:0]     rem_q, quo_q, divisor_q, div_b_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W:0]       rem_sh, trial;
    logic             take, last;
    logic [W-1:0]     rem_n, quo_n;

    always_comb begin
        rem_sh = {rem_q, quo_q[W-1]};
        trial  = rem_sh - {1'b0, divisor_q};
        take   = !trial[W];
        rem_n  = take ? trial[W-1:0] : rem_sh[W-1:0];
        quo_n  = {quo_q[W-2:0], take};
        last   = (cnt_q == LAST_STEP);
    end

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = DV_FIRST;
        end else begin
            unique case (state_q)
                DV_IDLE:   state_d = DV_IDLE;
                DV_FIRST:  if (last) state_d = DV_SECOND;
                DV_SECOND: if (last) state_d = DV_IDLE;
                default:   state_d = DV_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DV_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q     <= '0;
            quo_q     <= '0;
            divisor_q <= '0;
            div_b_q   <= '0;
            cnt_q     <= '0;
            quotient  <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q     <= '0;
                quo_q     <= numer;
                divisor_q <= div_a;
                div_b_q   <= div_b;
                cnt_q     <= '0;
            end else if (state_q != DV_IDLE) begin
                cnt_q <= cnt_q + 1'b1;
                if (last && state_q == DV_FIRST) begin
                    rem_q     <= '0;
                    quo_q     <= quo_n;
                    divisor_q <= div_b_q;
                    cnt_q     <= '0;
                end else if (last) begin
                    quotient <= quo_n;
                    done     <= 1'b1;
                end else begin
                    rem_q <= rem_n;
                    quo_q <= quo_n;
                end
            end
        end
    end

    assign busy = (state_q != DV_IDLE);

    assert_divisor_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (div_a != '0 && div_b != '0));
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/thermconv_convert.sv
module thermconv_convert
    import thermconv_pkg::*;
#(
    parameter int RAW_W  = 16,
    parameter int SENS_W = 3
) (
    input  logic [RAW_W-1:0]         raw,
    input  logic [SENS_W-1:0]        sensor,
    input  calib_t                   cal,
    input  logic signed [TEMP_W-1:0] gain,
    output logic signed [TEMP_W-1:0] temp
);
    logic [CODE_BITS-1:0]      code;
    logic [VTS_W-1:0]          vts_sel;
    logic signed [TEMP_W-1:0]  delta, prod, scaled, base, unfilt;

    always_comb begin
        code    = raw[CODE_BITS-1:0];
        vts_sel = '0;
        for (int i = 0; i < NUM_VTS; i++)
            if (int'(sensor) == i) vts_sel = cal.vts[i];
        delta  = $signed({{(TEMP_W-CODE_BITS){1'b0}}, code})
               - $signed({{(TEMP_W-VTS_W){1'b0}}, vts_sel}) - CODE_BIAS;
        prod   = gain * delta;
        scaled = prod >>> 3;
        base   = $signed({{(TEMP_W-DEGC_W){1'b0}}, cal.degc}) * 32'sd500;
        unfilt = base - scaled;
        temp   = (unfilt > SPIKE_LIMIT) ? '0 : unfilt;
    end
endmodule

// File: rtl/thermconv_top.sv
module thermconv_top
    import thermconv_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int RAW_W     = 16,
    parameter int SENS_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fuse_load,
    input  logic [31:0]                 fuse_w0,
    input  logic [31:0]                 fuse_w1,
    input  logic [31:0]                 fuse_w2,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [SENS_W-1:0]           in_sensor,
    input  logic [$clog2(NUM_BANKS)-1:0] in_bank,
    input  logic [RAW_W-1:0]            in_raw,
    input  logic                        in_last_bank,
    input  logic                        in_last_frame,
    output logic                        busy,
    output logic                        out_valid,
    output logic [NUM_BANKS*TEMP_W-1:0] bank_max,
    output logic [TEMP_W-1:0]           global_max
);
    localparam int BANK_W = $clog2(NUM_BANKS);

    ctl_state_t               state_q, state_d;
    calib_t                   cal_q, cal_dec;
    logic                     div_busy, div_done;
    logic [TEMP_W-1:0]        div_q;
    logic signed [TEMP_W-1:0] temp_conv, run_q, run_merge, glob_n, glob_q;
    logic signed [TEMP_W-1:0] stage_q [NUM_BANKS];
    logic signed [TEMP_W-1:0] stage_n [NUM_BANKS];
    logic signed [TEMP_W-1:0] bank_q  [NUM_BANKS];
    logic                     accept, closes;
    logic [TEMP_W-1:0]        div_a, div_b;

    thermconv_fuse_decode u_fuse (
        .w0(fuse_w0), .w1(fuse_w1), .w2(fuse_w2), .cal(cal_dec)
    );

    assign div_a = TEMP_W'(SLOPE_BASE + int'(cal_q.slope));
    assign div_b = TEMP_W'(GE_BASE) + TEMP_W'(cal_q.adc_ge);

    thermconv_gain_div #(.W(TEMP_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(state_q == CTL_START),
        .numer(GAIN_NUMER), .div_a(div_a), .div_b(div_b),
        .busy(div_busy), .done(div_done), .quotient(div_q)
    );

    thermconv_convert #(.RAW_W(RAW_W), .SENS_W(SENS_W)) u_conv (
        .raw(in_raw), .sensor(in_sensor), .cal(cal_q),
        .gain($signed(div_q)), .temp(temp_conv)
    );

    // control FSM
    always_comb begin
        state_d = state_q;
        if (fuse_load) begin
            state_d = CTL_START;
        end else begin
            unique case (state_q)
                CTL_START:  state_d = CTL_DIVIDE;
                CTL_DIVIDE: if (div_done) state_d = CTL_READY;
                CTL_READY:  state_d = CTL_READY;
                default:    state_d = CTL_START;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_START;
        else        state_q <= state_d;
    end

    assign in_ready = (state_q == CTL_READY);
    assign busy     = (state_q != CTL_READY);
    assign accept   = in_valid && in_ready;
    assign closes   = in_last_bank || in_last_frame;

    // bank and frame reduction
    always_comb begin
        run_merge = (temp_conv > run_q) ? temp_conv : run_q;
        for (int i = 0; i < NUM_BANKS; i++) begin
            stage_n[i] = stage_q[i];
            if (accept && closes && int'(in_bank) == i && run_merge > stage_q[i])
                stage_n[i] = run_merge;
        end
        glob_n = TEMP_FLOOR;
        for (int i = 0; i < NUM_BANKS; i++)
            if (stage_n[i] > glob_n) glob_n = stage_n[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q     <= calib_default();
            run_q     <= TEMP_FLOOR;
            glob_q    <= TEMP_FLOOR;
            out_valid <= 1'b0;
            for (int i = 0; i < NUM_BANKS; i++) begin
                stage_q[i] <= TEMP_FLOOR;
                bank_q[i]  <= TEMP_FLOOR;
            end
        end else begin
            if (fuse_load) cal_q <= cal_dec;
            out_valid <= accept && in_last_frame;
            if (accept) run_q <= closes ? TEMP_FLOOR : run_merge;
            for (int i = 0; i < NUM_BANKS; i++)
                stage_q[i] <= (accept && in_last_frame) ? TEMP_FLOOR : stage_n[i];
            if (accept && in_last_frame) begin
                glob_q <= glob_n;
                for (int i = 0; i < NUM_BANKS; i++) bank_q[i] <= stage_n[i];
            end
        end
    end

    assign global_max = glob_q;
    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_out
            assign bank_max[g*TEMP_W +: TEMP_W] = bank_q[g];
            assert_global_covers_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> ($signed(global_max) >= bank_q[g]));
        end
    endgenerate

    assert_no_accept_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || div_busy) |-> !in_ready);
    assert_spike_clamped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (temp_conv <= SPIKE_LIMIT));
    assert_sensor_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (int'(in_sensor) < NUM_VTS));
    assert_strobe_follows_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready && in_last_frame));
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(global_max));
endmodule

// File: tb/tb_thermconv_top.sv
module tb_thermconv_top;
    localparam int NB = 4;

    logic clk = 0, rst_n = 0;
    logic fuse_load = 0;
    logic [31:0] fuse_w0 = 0, fuse_w1 = 0, fuse_w2 = 0;
    logic in_valid = 0, in_last_bank = 0, in_last_frame = 0;
    logic [2:0] in_sensor = 0;
    logic [1:0] in_bank = 0;
    logic [15:0] in_raw = 0;
    logic in_ready, busy, out_valid;
    logic [NB*32-1:0] bank_max;
    logic [31:0] global_max;

    int checks = 0, errors = 0;
    int ge, dc, os;
    int vts [5];
    int b_s [16], b_b [16], b_r [16], b_lb [16], b_lf [16];
    localparam int MINV = 32'sh8000_0000;

    always #4 clk = ~clk;

    thermconv_top dut (
        .clk(clk), .rst_n(rst_n), .fuse_load(fuse_load),
        .fuse_w0(fuse_w0), .fuse_w1(fuse_w1), .fuse_w2(fuse_w2),
        .in_valid(in_valid), .in_ready(in_ready), .in_sensor(in_sensor),
        .in_bank(in_bank), .in_raw(in_raw), .in_last_bank(in_last_bank),
        .in_last_frame(in_last_frame), .busy(busy), .out_valid(out_valid),
        .bank_max(bank_max), .global_max(global_max)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model(input int raw, input int s);
        int g, d, p, t;
        g = (1627604160 / (165 + os)) / (10000 + ge);
        d = (raw & 32'hfff) - vts[s] - 3350;
        p = g * d;
        p = p >>> 3;
        t = dc * 500 - p;
        if (t > 200000) t = 0;
        return t;
    endfunction

    task automatic set_defaults();
        ge = 512; dc = 40; os = 0;
        for (int i = 0; i < 5; i++) vts[i] = 260;
    endtask

    // load fuse words; fields per R9, sign rule per R10, valid bit per R11
    task automatic load_fuse(input bit valid, input int g, input int d, input int mag,
                             input bit sgn, input bit id, input int v0, input int v1,
                             input int v2, input int v3, input int v4);
        int n;
        @(negedge clk);
        fuse_w0 = {mag[5:0], v0[8:0], v1[8:0], sgn, d[5:0], valid};
        fuse_w1 = {g[9:0], 12'h000, id, v2[8:0]};
        fuse_w2 = {v3[8:0], v4[8:0], 14'h2a5};
        fuse_load = 1;
        @(negedge clk);
        fuse_load = 0;
        chk("R2 busy after load", int'(busy), 1);
        chk("R2 not ready after load", int'(in_ready), 0);
        n = 0;
        while (busy && n < 100) begin @(negedge clk); n++; end
        chk("R2 gain ready in time", int'(busy), 0);
        if (valid) begin
            ge = g; dc = d; os = (sgn && id) ? -mag : mag;
            vts[0] = v0; vts[1] = v1; vts[2] = v2; vts[3] = v3; vts[4] = v4;
        end else set_defaults();
    endtask

    task automatic run_frame(input int n, input string tag);
        int run, glob, t;
        int stg [NB];
        run = MINV;
        for (int i = 0; i < NB; i++) stg[i] = MINV;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1; in_sensor = 3'(b_s[k]); in_bank = 2'(b_b[k]);
            in_raw = 16'(b_r[k]); in_last_bank = b_lb[k][0]; in_last_frame = b_lf[k][0];
            t = model(b_r[k], b_s[k]);
            if (t > run) run = t;
            if (b_lb[k] != 0 || b_lf[k] != 0) begin
                if (run > stg[b_b[k]]) stg[b_b[k]] = run;
                run = MINV;
            end
        end
        @(negedge clk);
        in_valid = 0; in_last_bank = 0; in_last_frame = 0;
        glob = MINV;
        for (int i = 0; i < NB; i++) if (stg[i] > glob) glob = stg[i];
        chk({tag, " R7 strobe"}, int'(out_valid), 1);
        for (int i = 0; i < NB; i++) chk({tag, " R5 bank"}, int'(bank_max[i*32 +: 32]), stg[i]);
        chk({tag, " R6 global"}, int'(global_max), glob);
        @(negedge clk);
        chk({tag, " R7 strobe one cycle"}, int'(out_valid), 0);
    endtask

    task automatic sweep(input string tag);
        for (int s = 0; s < 5; s++)
            for (int r = 0; r < 4096 + 91; r += 91) begin
                b_s[0] = s; b_b[0] = s % NB; b_r[0] = (r > 4095) ? 4095 : r;
                b_lb[0] = 1; b_lf[0] = 1;
                run_frame(1, {tag, " R3 R4 sweep"});
            end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_defaults();
        repeat (3) @(negedge clk);
        chk("R8 out_valid reset", int'(out_valid), 0);
        chk("R8 global reset", int'(global_max), MINV);
        chk("R8 bank reset", int'(bank_max[63:32]), MINV);
        chk("R8 busy reset", int'(busy), 1);
        rst_n = 1;
        begin
            int n = 0;
            while (busy && n < 100) begin @(negedge clk); n++; end
            chk("R2 R8 gain after reset", int'(busy), 0);
        end
        sweep("defaults R8");

        // R1: high bits of raw ignored
        b_s[0] = 1; b_b[0] = 0; b_r[0] = 16'hF000 | 3500; b_lb[0] = 0; b_lf[0] = 0;
        b_s[1] = 2; b_b[1] = 0; b_r[1] = 16'h5000 | 3400; b_lb[1] = 0; b_lf[1] = 1;
        run_frame(2, "R1 masked");
        chk("R1 value equals low code", int'(global_max),
            (model(3500, 1) > model(3400, 2)) ? model(3500, 1) : model(3400, 2));

        // R9 positive slope (sign set, id clear)
        load_fuse(1, 700, 45, 20, 1, 0, 300, 250, 120, 400, 511);
        sweep("R9 fused");
        // R10 negative slope
        load_fuse(1, 1023, 63, 63, 1, 1, 0, 511, 77, 260, 199);
        sweep("R10 negated");
        // R10 id set, sign clear -> positive
        load_fuse(1, 0, 1, 63, 0, 1, 15, 40, 500, 333, 2);
        sweep("R10 id only");
        // R11 invalid image restores defaults
        load_fuse(0, 999, 7, 50, 1, 1, 1, 2, 3, 4, 5);
        sweep("R11 defaults");

        // R5 R6 multi-bank frame with a spike, bank 1 closed twice, bank 3 unclosed
        b_s[0] = 0; b_b[0] = 0; b_r[0] = 3700; b_lb[0] = 0; b_lf[0] = 0;
        b_s[1] = 1; b_b[1] = 0; b_r[1] = 3900; b_lb[1] = 1; b_lf[1] = 0;
        b_s[2] = 2; b_b[2] = 1; b_r[2] = 0;    b_lb[2] = 0; b_lf[2] = 0;
        b_s[3] = 3; b_b[3] = 1; b_r[3] = 4000; b_lb[3] = 1; b_lf[3] = 0;
        b_s[4] = 4; b_b[4] = 1; b_r[4] = 3000; b_lb[4] = 1; b_lf[4] = 0;
        b_s[5] = 0; b_b[5] = 2; b_r[5] = 3650; b_lb[5] = 0; b_lf[5] = 1;
        run_frame(6, "R5 R6 multi");
        chk("R6 unclosed bank", int'(bank_max[3*32 +: 32]), MINV);

        // R7 hold while a later frame is partly received
        begin
            int held;
            held = int'(global_max);
            @(negedge clk);
            in_valid = 1; in_sensor = 0; in_bank = 2; in_raw = 100; in_last_bank = 1;
            @(negedge clk);
            in_bank = 0; in_raw = 3000; in_last_bank = 0;
            @(negedge clk);
            in_valid = 0; in_last_bank = 0;
            repeat (3) @(negedge clk);
            chk("R7 no strobe mid frame", int'(out_valid), 0);
            chk("R7 global held", int'(global_max), held);
        end
        b_s[0] = 4; b_b[0] = 3; b_r[0] = 3800; b_lb[0] = 0; b_lf[0] = 1;
        begin
            int t1, t2, t3, g;
            t1 = model(100, 0); t2 = model(3000, 0); t3 = model(3800, 4);
            @(negedge clk);
            in_valid = 1; in_sensor = 4; in_bank = 3; in_raw = 3800; in_last_frame = 1;
            @(negedge clk);
            in_valid = 0; in_last_frame = 0;
            g = t1; if (t2 > g) g = t2; if (t3 > g) g = t3;
            chk("R5 bank2 from partial", int'(bank_max[2*32 +: 32]), t1);
            chk("R5 bank3 run includes open beat", int'(bank_max[3*32 +: 32]), (t2 > t3) ? t2 : t3);
            chk("R6 global after partial", int'(global_max), g);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule